// File: doc/BRIEF.md
# Debug-port reset and interrupt unit

This unit hangs off a four-wire test access port and turns debug commands into two requests toward the processor: a chip-level power-on reset request and an interrupt request. An 8-bit instruction register is shifted in through the port. One command raises the reset request. A second command drops it, so the debugger controls how long the reset lasts. A third command selects a one-bit interrupt data register. Scanning a 1 into that register sets a sticky pending bit in the peripheral clock domain.

Update events cross from the test clock to the peripheral clock through toggle handshakes and two-flop synchronizers. Both requests are driven from peripheral-clock flops. Software sees the pending bit and a 4-bit priority value through a small register port. Software can clear the pending bit, and a priority of zero masks the request. While the request is active, the unit presents the fixed exception code 0x600.

Top module: `jdbg_unit`

## Requirements
- R1: After an Update-IR that loads code 0x01, reset_req goes high and stays high through later loads of any code other than 0x02. A load of 0x02 returns it low.
- R2: Holding trst_n low across a rising tck edge, or entering Test-Logic-Reset through TMS, drops reset_req and selects the bypass register.
- R3: With code 0x03 in the instruction register, an Update-DR that carries a shifted 1 sets the pending interrupt bit. irq_req is high whenever that bit is set and the priority is nonzero.
- R4: The pending bit stays set until software writes 0 to bit 0 with sw_sel=0. A software write of 1 is ignored, and a test-port reset does not clear the bit.
- R5: The instruction register changes only at Update-IR, in Test-Logic-Reset, or under trst_n. Code 0x03 stays loaded across later data scans. Every IR scan captures 0x01.
- R6: With code 0x03 loaded, the data path is one bit that captures the current pending bit. With every other code, it is a one-bit bypass register that captures 0. An Update-DR under code 0x03 with a shifted 0 leaves the pending bit unchanged.
- R7: irq_code reads 0x600 while irq_req is high, and 0 otherwise.
- R8: A write with sw_sel=1 stores sw_wdata[3:0] as the priority. It reads back on sw_rdata when sw_sel=1, and sw_sel=0 reads the pending bit in bit 0. A priority of 0 keeps irq_req low while the bit stays pending.
- R9: tdo changes only on falling tck edges and shifts out the least significant bit first.
- R10: rst clears reset_req, the pending bit and the priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset, peripheral domain |
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Test-port reset, active low, sampled on tck |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling tck |
| sw_we | input | 1 | Software write strobe |
| sw_sel | input | 1 | 0 selects the interrupt control bit, 1 selects the priority |
| sw_wdata | input | 4 | Software write data |
| sw_rdata | output | 4 | Software read data for sw_sel |
| reset_req | output | 1 | Power-on reset request |
| irq_req | output | 1 | Interrupt request |
| irq_code | output | 12 | Exception code while irq_req is high |

## Verification
The case hardest to reach from the ports is a data-register capture that returns the pending bit. The bit has to travel to the peripheral domain and back into the test-clock domain before the next Capture-DR. The bench sets the bit with one interrupt scan and then runs a second scan under the same command, shifting a 0. That second scan shows three things at once: the bit read back, the command still in place, and no clear through the scan path. Every one of the 256 instruction codes is also swept with an IR scan followed by a DR scan of 1. A test-port reset is applied while both requests are active.

// File: rtl/jdbg_pkg.sv
package jdbg_pkg;

    localparam int IR_W = 8;
    typedef logic [IR_W-1:0] ir_t;

    localparam ir_t CMD_RST_ON  = 8'h01;
    localparam ir_t CMD_RST_OFF = 8'h02;
    localparam ir_t CMD_IRQ     = 8'h03;
    localparam ir_t CMD_BYPASS  = 8'hFF;
    localparam ir_t IR_CAPTURE  = 8'h01;

    localparam int CODE_W = 12;
    localparam logic [CODE_W-1:0] IRQ_EXC_CODE = 12'h600;

    typedef enum logic [3:0] {
        S_TLR, S_RTI,
        S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PAUSE_DR, S_EX2_DR, S_UPD_DR,
        S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PAUSE_IR, S_EX2_IR, S_UPD_IR
    } tap_t;

    typedef enum logic [1:0] {OP_PASS, OP_RST_ON, OP_RST_OFF, OP_IRQ} op_t;

    typedef struct packed {
        logic tgl;
        ir_t  code;
    } ir_evt_t;

    typedef struct packed {
        logic tgl;
        logic bit_v;
    } dr_evt_t;

    function automatic op_t decode_ir(ir_t v);
        case (v)
            CMD_RST_ON:  return OP_RST_ON;
            CMD_RST_OFF: return OP_RST_OFF;
            CMD_IRQ:     return OP_IRQ;
            default:     return OP_PASS;
        endcase
    endfunction

    function automatic tap_t tap_next(tap_t s, logic tms);
        case (s)
            S_TLR:      return tms ? S_TLR      : S_RTI;
            S_RTI:      return tms ? S_SEL_DR   : S_RTI;
            S_SEL_DR:   return tms ? S_SEL_IR   : S_CAP_DR;
            S_CAP_DR:   return tms ? S_EX1_DR   : S_SH_DR;
            S_SH_DR:    return tms ? S_EX1_DR   : S_SH_DR;
            S_EX1_DR:   return tms ? S_UPD_DR   : S_PAUSE_DR;
            S_PAUSE_DR: return tms ? S_EX2_DR   : S_PAUSE_DR;
            S_EX2_DR:   return tms ? S_UPD_DR   : S_SH_DR;
            S_UPD_DR:   return tms ? S_SEL_DR   : S_RTI;
            S_SEL_IR:   return tms ? S_TLR      : S_CAP_IR;
            S_CAP_IR:   return tms ? S_EX1_IR   : S_SH_IR;
            S_SH_IR:    return tms ? S_EX1_IR   : S_SH_IR;
            S_EX1_IR:   return tms ? S_UPD_IR   : S_PAUSE_IR;
            S_PAUSE_IR: return tms ? S_EX2_IR   : S_PAUSE_IR;
            S_EX2_IR:   return tms ? S_UPD_IR   : S_SH_IR;
            S_UPD_IR:   return tms ? S_SEL_DR   : S_RTI;
            default:    return S_TLR;
        endcase
    endfunction

endpackage

// File: rtl/jdbg_sync.sv
module jdbg_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        stg[0] <= d;
        for (int i = 1; i < STAGES; i++) begin
            stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/jdbg_tap_ctrl.sv
module jdbg_tap_ctrl
    import jdbg_pkg::*;
(
    input  logic tck,
    input  logic trst_n,
    input  logic tms,
    output tap_t state
);
    always_ff @(posedge tck) begin
        if (!trst_n) state <= S_TLR;
        else         state <= tap_next(state, tms);
    end
endmodule

// File: rtl/jdbg_scan_path.sv
module jdbg_scan_path
    import jdbg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    tck,
    input  logic    trst_n,
    input  logic    tdi,
    input  tap_t    state,
    input  logic    intreq_pclk,
    output logic    tdo,
    output ir_evt_t ir_evt,
    output dr_evt_t dr_evt,
    output logic    in_tlr
);
    ir_t  ir, ir_sh;
    logic dr_q;
    logic intreq_tck;
    logic irq_sel;

    jdbg_sync #(.W(1), .STAGES(SYNC_STAGES)) u_back (
        .clk(tck), .d(intreq_pclk), .q(intreq_tck)
    );

    assign irq_sel = (decode_ir(ir) == OP_IRQ);
    assign in_tlr  = (state == S_TLR);
    assign ir_evt.code = ir;

    always_ff @(posedge tck) begin
        if (!trst_n) begin
            ir           <= CMD_BYPASS;
            ir_sh        <= '0;
            dr_q         <= 1'b0;
            ir_evt.tgl   <= 1'b0;
            dr_evt.tgl   <= 1'b0;
            dr_evt.bit_v <= 1'b0;
        end else begin
            case (state)
                S_TLR:    ir    <= CMD_BYPASS;
                S_CAP_IR: ir_sh <= IR_CAPTURE;
                S_SH_IR:  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
                S_UPD_IR: begin
                    ir         <= ir_sh;
                    ir_evt.tgl <= ~ir_evt.tgl;
                end
                S_CAP_DR: dr_q <= irq_sel ? intreq_tck : 1'b0;
                S_SH_DR:  dr_q <= tdi;
                S_UPD_DR: if (irq_sel) begin
                    dr_evt.bit_v <= dr_q;
                    dr_evt.tgl   <= ~dr_evt.tgl;
                end
                default: ;
            endcase
        end
    end

    always_ff @(negedge tck) begin
        if (!trst_n)                tdo <= 1'b0;
        else if (state == S_SH_IR)  tdo <= ir_sh[0];
        else if (state == S_SH_DR)  tdo <= dr_q;
    end

    AST_IR_ONLY_AT_UPDATE: assert property (@(posedge tck) disable iff (!trst_n)
        (state != S_UPD_IR && state != S_TLR) |=> $stable(ir)); // R5
    AST_DR_EVT_NEEDS_CMD: assert property (@(posedge tck) disable iff (!trst_n)
        (dr_evt.tgl != $past(dr_evt.tgl)) |-> (decode_ir(ir) == OP_IRQ)); // R6
endmodule

// File: rtl/jdbg_unit.sv
module jdbg_unit
    import jdbg_pkg::*;
#(
    parameter int PRIO_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              pclk,
    input  logic              rst,
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tms,
    input  logic              tdi,
    output logic              tdo,
    input  logic              sw_we,
    input  logic              sw_sel,
    input  logic [PRIO_W-1:0] sw_wdata,
    output logic [PRIO_W-1:0] sw_rdata,
    output logic              reset_req,
    output logic              irq_req,
    output logic [CODE_W-1:0] irq_code
);
    localparam int IRP_W = $bits(ir_evt_t);
    localparam int DRP_W = $bits(dr_evt_t);

    tap_t    state;
    ir_evt_t ir_t_side, ir_p_side;
    dr_evt_t dr_t_side, dr_p_side;
    logic    tlr_t, tlr_p;
    logic    intreq;
    logic    ir_tgl_d, dr_tgl_d;
    logic    ir_fire, dr_fire, dr_set, sw_clr;
    logic [PRIO_W-1:0] prio;

    jdbg_tap_ctrl u_tap (
        .tck(tck), .trst_n(trst_n), .tms(tms), .state(state)
    );

    jdbg_scan_path #(.SYNC_STAGES(SYNC_STAGES)) u_scan (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(state),
        .intreq_pclk(intreq), .tdo(tdo),
        .ir_evt(ir_t_side), .dr_evt(dr_t_side), .in_tlr(tlr_t)
    );

    jdbg_sync #(.W(IRP_W), .STAGES(SYNC_STAGES)) u_ir_x (
        .clk(pclk), .d(ir_t_side), .q(ir_p_side)
    );
    jdbg_sync #(.W(DRP_W), .STAGES(SYNC_STAGES)) u_dr_x (
        .clk(pclk), .d(dr_t_side), .q(dr_p_side)
    );
    jdbg_sync #(.W(1), .STAGES(SYNC_STAGES)) u_tlr_x (
        .clk(pclk), .d(tlr_t), .q(tlr_p)
    );

    assign ir_fire = ir_p_side.tgl ^ ir_tgl_d;
    assign dr_fire = dr_p_side.tgl ^ dr_tgl_d;
    assign dr_set  = dr_fire && dr_p_side.bit_v;
    assign sw_clr  = sw_we && !sw_sel && !sw_wdata[0];

    always_ff @(posedge pclk) begin
        if (rst) begin
            ir_tgl_d  <= ir_p_side.tgl;
            dr_tgl_d  <= dr_p_side.tgl;
            reset_req <= 1'b0;
            intreq    <= 1'b0;
            prio      <= '0;
        end else begin
            ir_tgl_d <= ir_p_side.tgl;
            dr_tgl_d <= dr_p_side.tgl;
            if (tlr_p) begin
                reset_req <= 1'b0;
            end else if (ir_fire) begin
                case (decode_ir(ir_p_side.code))
                    OP_RST_ON:  reset_req <= 1'b1;
                    OP_RST_OFF: reset_req <= 1'b0;
                    default: ;
                endcase
            end
            if (dr_set)      intreq <= 1'b1;
            else if (sw_clr) intreq <= 1'b0;
            if (sw_we && sw_sel) prio <= sw_wdata;
        end
    end

    assign irq_req  = intreq && (prio != '0);
    assign irq_code = irq_req ? IRQ_EXC_CODE : '0;
    assign sw_rdata = sw_sel ? prio : {{(PRIO_W-1){1'b0}}, intreq};

    AST_RST_HELD: assert property (@(posedge pclk) disable iff (rst)
        (reset_req && !tlr_p && !ir_fire) |=> reset_req); // R1
    AST_TLR_DROPS_RST: assert property (@(posedge pclk) disable iff (rst)
        tlr_p |=> !reset_req); // R2
    AST_IRQ_STICKY: assert property (@(posedge pclk) disable iff (rst)
        (intreq && !sw_clr) |=> intreq); // R4
    AST_NO_SW_SET: assert property (@(posedge pclk) disable iff (rst)
        (!intreq && !dr_set) |=> !intreq); // R4
    AST_SET_FROM_SCAN: assert property (@(posedge pclk) disable iff (rst)
        $rose(intreq) |-> $past(dr_fire)); // R3
endmodule

// File: tb/tb_jdbg_unit.sv
module tb_jdbg_unit;
    logic pclk = 1'b0, rst = 1'b1;
    logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
    logic tdo;
    logic sw_we = 1'b0, sw_sel = 1'b0;
    logic [3:0] sw_wdata = 4'h0;
    logic [3:0] sw_rdata;
    logic reset_req, irq_req;
    logic [11:0] irq_code;

    int total = 0, bad = 0;

    jdbg_unit dut (
        .pclk(pclk), .rst(rst), .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
        .tdo(tdo), .sw_we(sw_we), .sw_sel(sw_sel), .sw_wdata(sw_wdata),
        .sw_rdata(sw_rdata), .reset_req(reset_req), .irq_req(irq_req), .irq_code(irq_code)
    );

    always #5 pclk = ~pclk;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tclk(input logic m, input logic d, output logic o);
        tms = m; tdi = d;
        #20 o = tdo;
        tck = 1'b1;
        #40 tck = 1'b0;
        #20;
    endtask

    task automatic idle(input int n);
        logic o;
        for (int i = 0; i < n; i++) tclk(1'b0, 1'b0, o);
    endtask

    task automatic scan_ir(input logic [7:0] v, output logic [7:0] cap);
        logic o;
        tclk(1, 0, o); tclk(1, 0, o); tclk(0, 0, o); tclk(0, 0, o);
        for (int i = 0; i < 8; i++) begin
            tclk(i == 7, v[i], o);
            cap[i] = o;
        end
        tclk(1, 0, o); tclk(0, 0, o);
        idle(2);
    endtask

    task automatic scan_dr(input logic b, output logic cap);
        logic o;
        tclk(1, 0, o); tclk(0, 0, o); tclk(0, 0, o);
        tclk(1, b, cap);
        tclk(1, 0, o); tclk(0, 0, o);
        idle(2);
    endtask

    task automatic sw_write(input logic sel, input logic [3:0] d);
        @(negedge pclk);
        sw_we = 1'b1; sw_sel = sel; sw_wdata = d;
        @(negedge pclk);
        sw_we = 1'b0; sw_sel = 1'b0;
        @(negedge pclk);
    endtask

    initial begin
        logic [7:0] cap;
        logic       dcap, o;
        logic       exp_rr;
        // R10 reset state
        for (int i = 0; i < 3; i++) tclk(1, 0, o);
        repeat (4) @(negedge pclk);
        rst = 1'b0;
        trst_n = 1'b1;
        tclk(0, 0, o);
        idle(1);
        chk("R10 reset_req after reset", reset_req, 0);
        chk("R10 irq_req after reset", irq_req, 0);
        chk("R7 irq_code idle", irq_code, 0);
        chk("R10 intreq read after reset", sw_rdata, 0);

        // R8 priority
        sw_write(1'b1, 4'h5);
        sw_sel = 1'b1; #1;
        chk("R8 priority readback", sw_rdata, 5);
        sw_sel = 1'b0;

        // R1 hold across other codes
        scan_ir(8'h01, cap);
        chk("R1 reset_req set", reset_req, 1);
        scan_ir(8'h03, cap);
        scan_ir(8'hFF, cap);
        scan_ir(8'h55, cap);
        chk("R1 reset_req held over other codes", reset_req, 1);
        scan_ir(8'h02, cap);
        chk("R1 reset_req dropped by 0x02", reset_req, 0);

        // Sweep every code: R5 capture, R6 data path, R1 model, R3/R4/R7
        exp_rr = 1'b0;
        for (int c = 0; c < 256; c++) begin
            scan_ir(c[7:0], cap);
            chk("R5 IR capture value", cap, 8'h01);
            if (c == 1) exp_rr = 1'b1;
            else if (c == 2) exp_rr = 1'b0;
            chk("R1 reset_req vs code", reset_req, exp_rr);
            scan_dr(1'b1, dcap);
            chk("R6 DR capture", dcap, 0);
            if (c == 3) begin
                chk("R3 pending set by scan", sw_rdata[0], 1);
                chk("R3 irq_req raised", irq_req, 1);
                chk("R7 irq_code 0x600", irq_code, 12'h600);
                sw_write(1'b0, 4'h1);
                chk("R4 sw write 1 ignored", irq_req, 1);
                scan_dr(1'b0, dcap);
                chk("R6 DR captures pending bit", dcap, 1);
                chk("R6 shifted 0 leaves bit set", irq_req, 1);
                sw_write(1'b0, 4'h0);
                chk("R4 sw write 0 clears", irq_req, 0);
                chk("R7 irq_code cleared", irq_code, 0);
                scan_dr(1'b0, dcap);
                chk("R5 IR still interrupt, captures cleared bit", dcap, 0);
            end else begin
                chk("R6 bypass scan sets nothing", sw_rdata[0], 0);
            end
        end

        // R2 trst with both requests active
        scan_ir(8'h01, cap);
        scan_ir(8'h03, cap);
        scan_dr(1'b1, dcap);
        chk("R1 reset_req before trst", reset_req, 1);
        chk("R3 irq before trst", irq_req, 1);
        trst_n = 1'b0;
        tclk(0, 0, o); tclk(0, 0, o);
        trst_n = 1'b1;
        tclk(0, 0, o);
        idle(1);
        chk("R2 trst drops reset_req", reset_req, 0);
        chk("R4 trst keeps pending irq", irq_req, 1);
        scan_dr(1'b1, dcap);
        chk("R2 IR bypass after trst", dcap, 0);

        // R2 TLR via TMS
        scan_ir(8'h01, cap);
        chk("R1 reset_req set again", reset_req, 1);
        for (int i = 0; i < 5; i++) tclk(1, 0, o);
        tclk(0, 0, o);
        idle(1);
        chk("R2 TLR drops reset_req", reset_req, 0);

        // R8 masking
        sw_write(1'b1, 4'h0);
        chk("R8 prio 0 masks irq", irq_req, 0);
        chk("R8 bit still pending", sw_rdata[0], 1);
        sw_write(1'b1, 4'hA);
        chk("R8 unmask restores irq", irq_req, 1);

        // R9 tdo on falling edge
        tclk(1, 0, o); tclk(1, 0, o); tclk(0, 0, o); tclk(0, 0, o);
        chk("R9 first IR bit out", tdo, 1);
        tms = 1'b0; tdi = 1'b0;
        #20 tck = 1'b1;
        #5 chk("R9 tdo held after rising edge", tdo, 1);
        #35 tck = 1'b0;
        #5 chk("R9 tdo updated after falling edge", tdo, 0);
        #15;
        for (int i = 0; i < 5; i++) tclk(1, 0, o);
        tclk(0, 0, o);

        // R10 system reset
        scan_ir(8'h01, cap);
        @(negedge pclk) rst = 1'b1;
        repeat (2) @(negedge pclk);
        rst = 1'b0;
        repeat (6) @(negedge pclk);
        chk("R10 rst clears reset_req", reset_req, 0);
        chk("R10 rst clears irq", irq_req, 0);
        sw_sel = 1'b1; #1;
        chk("R10 rst clears priority", sw_rdata, 0);
        sw_sel = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge pclk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule